// File: doc/BRIEF.md
# Burst-Limited FIFO Transfer Splitter

This block moves a block of bytes of any length into or out of the data FIFO register of a register-mapped slave. The slave may only be able to take or supply a limited number of bytes at a time. It advertises that limit, the burst count, in a field of its 32-bit status register. The splitter therefore cuts the block into chunks. Before every chunk it reads the status register. It sizes the chunk from the burst count just read, the bytes still to move and a fixed per-frame ceiling. It then issues one FIFO transaction of that size.

The requests go to a register transaction framer. Each request carries a direction, a 24-bit register address and a byte count. The framer returns received bytes on a single byte stream. For a read of the data FIFO, those bytes are forwarded to the user's read stream. For a write, bytes from the user's write stream are passed to the framer, exactly as many as the chunk holds.

A status read that shows a burst count of zero means the slave is busy, and the read is repeated. A bounded number of consecutive busy answers ends the transfer with an error pulse.

Top module: `fifo_burst_splitter`

## Requirements
- R1: Every FIFO transaction carries a byte count, on `req_cnt`, equal to the smallest of three values: the bytes still to move, the burst count read just before it, and 64.
- R2: A status read is issued with `req_rnw`=1, address 0xD40018 and a count of 4. A FIFO transaction uses address 0xD40024 with `req_rnw` equal to the start direction (1 = read from the slave, 0 = write to it).
- R3: Each FIFO transaction is preceded by its own status read. The burst count is bits 23:8 of the status word assembled little-endian, with the first received byte forming bits 7:0.
- R4: A status read that yields a burst count of zero is followed by another status read and no FIFO transaction. After a nonzero count the transfer proceeds normally.
- R5: After ZERO_LIMIT consecutive zero burst counts, `err` pulses for one cycle and the block returns to idle without any FIFO transaction. The run of zeros is counted afresh after every nonzero count.
- R6: During a FIFO read chunk, each byte received from the framer appears on `rd_valid`/`rd_data` in the same cycle and in order. Status bytes and bytes outside a read chunk never appear there.
- R7: During a FIFO write chunk, `wr_in` bytes pass to `wr_out` unchanged and in order, exactly the chunk's count. Outside a write chunk `wr_out_valid` and `wr_in_ready` stay low.
- R8: When the bytes handled equal the requested length, `done` pulses for exactly one cycle and `busy` is low in that cycle.
- R9: A start with length 0 pulses `done` in the following cycle and issues no request.
- R10: A start asserted while `busy` is high is ignored. The running transfer keeps its length and direction.
- R11: After reset, `busy`, `done`, `err` and `req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| start_len | input | LEN_W | Total bytes to move |
| start_dir | input | 1 | 1 = read from slave FIFO, 0 = write to it |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse: all bytes moved |
| err | output | 1 | One-cycle pulse: busy-retry limit reached |
| req_valid | output | 1 | Request to the framer is valid |
| req_ready | input | 1 | Framer accepts the request |
| req_rnw | output | 1 | 1 = register read, 0 = register write |
| req_addr | output | ADDR_W | Register address |
| req_cnt | output | CNT_W | Bytes in the transaction |
| rsp_valid | input | 1 | Byte received from the framer |
| rsp_data | input | 8 | Received byte |
| rd_valid | output | 1 | FIFO read byte to the user |
| rd_data | output | 8 | FIFO read byte value |
| wr_in_valid | input | 1 | User write byte available |
| wr_in_ready | output | 1 | User write byte taken |
| wr_in_data | input | 8 | User write byte |
| wr_out_valid | output | 1 | Write byte offered to the framer |
| wr_out_ready | input | 1 | Framer takes the write byte |
| wr_out_data | output | 8 | Write byte to the framer |

## Verification
A wrong chunk counter or remaining-length register shows up at the next FIFO request as a `req_cnt` that differs from the minimum the bench computes. It can also show up as a `done` that arrives early, late or not at all, measured against the bytes the bench counted. A fault in the status assembly or in the burst field position changes the very next chunk size. A broken retry counter shows as too many or too few status reads before `err`. Leaks in the data gate surface within a cycle as stray `rd_valid` or `wr_out_valid` outside a chunk.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_STS_REQ,
      ST_STS_RX,
      ST_FIFO_REQ,
      ST_FIFO_DATA
   } fbs_state_t;

endpackage

// File: rtl/fbs_status_capture.sv
module fbs_status_capture #(
   parameter int NBYTES = 4,
   parameter bit LITTLE = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clear,
   input  logic                byte_valid,
   input  logic [7:0]          byte_data,
   output logic [NBYTES*8-1:0] word,
   output logic                full
);
   localparam int IW = $clog2(NBYTES + 1);

   logic [IW-1:0] idx_q;
   logic [7:0]    bytes_q [NBYTES];
   logic          take;

   assign full = (idx_q == IW'(NBYTES));
   assign take = byte_valid && !full && !clear;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
         for (int i = 0; i < NBYTES; i++) bytes_q[i] <= '0;
      end else begin
         if (clear) idx_q <= '0;
         else if (take) idx_q <= idx_q + 1'b1;
         for (int i = 0; i < NBYTES; i++)
            if (take && idx_q == IW'(i)) bytes_q[i] <= byte_data;
      end
   end

   generate
      for (genvar g = 0; g < NBYTES; g++) begin : g_map
         if (LITTLE) begin : g_le
            assign word[g*8 +: 8] = bytes_q[g];
         end else begin : g_be
            assign word[(NBYTES-1-g)*8 +: 8] = bytes_q[g];
         end
      end
   endgenerate

   // R3
   cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !clear) |=> full);

endmodule

// File: rtl/fbs_chunk_size.sv
module fbs_chunk_size #(
   parameter int LEN_W     = 16,
   parameter int BURST_W   = 16,
   parameter int MAX_CHUNK = 64,
   parameter int CNT_W     = 7
) (
   input  logic [LEN_W-1:0]   remaining,
   input  logic [BURST_W-1:0] burst,
   output logic [CNT_W-1:0]   chunk
);
   localparam int MW = (LEN_W > BURST_W) ? LEN_W : BURST_W;
   localparam int W  = (MW > CNT_W) ? MW : CNT_W;

   logic [W-1:0] rem_x, bur_x, cap_x, m1, m2;

   always_comb begin
      rem_x = W'(remaining);
      bur_x = W'(burst);
      cap_x = W'(MAX_CHUNK);
      m1    = (rem_x < bur_x) ? rem_x : bur_x;
      m2    = (m1 < cap_x) ? m1 : cap_x;
      chunk = CNT_W'(m2);
   end

endmodule

// File: rtl/fbs_data_gate.sv
module fbs_data_gate #(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_cnt,
   input  logic             is_read,
   input  logic             rsp_valid,
   input  logic [7:0]       rsp_data,
   output logic             rd_valid,
   output logic [7:0]       rd_data,
   input  logic             wr_in_valid,
   output logic             wr_in_ready,
   input  logic [7:0]       wr_in_data,
   output logic             wr_out_valid,
   input  logic             wr_out_ready,
   output logic [7:0]       wr_out_data,
   output logic             last
);
   logic [CNT_W-1:0] left_q;
   logic             active, beat, take;

   assign active       = (left_q != '0);
   assign beat         = is_read ? rsp_valid : (wr_in_valid && wr_out_ready);
   assign take         = active && beat;
   assign last         = take && (left_q == CNT_W'(1));
   assign rd_valid     = active && is_read && rsp_valid;
   assign rd_data      = rsp_data;
   assign wr_out_valid = active && !is_read && wr_in_valid;
   assign wr_in_ready  = active && !is_read && wr_out_ready;
   assign wr_out_data  = wr_in_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) left_q <= '0;
      else if (load) left_q <= load_cnt;
      else if (take) left_q <= left_q - 1'b1;
   end

   // R7
   gate_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !active);

endmodule

// File: rtl/fifo_burst_splitter.sv
module fifo_burst_splitter
   import fbs_pkg::*;
#(
   parameter int          LEN_W      = 16,
   parameter int          ADDR_W     = 24,
   parameter int          MAX_CHUNK  = 64,
   parameter int          BURST_LSB  = 8,
   parameter int          BURST_W    = 16,
   parameter int          STS_BYTES  = 4,
   parameter bit          STS_LE     = 1'b1,
   parameter int          ZERO_LIMIT = 1000,
   parameter logic [23:0] BASE_ADDR  = 24'hD40000,
   parameter logic [23:0] STS_OFS    = 24'h000018,
   parameter logic [23:0] FIFO_OFS   = 24'h000024,
   localparam int         CNT_W      = $clog2(MAX_CHUNK + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [LEN_W-1:0]  start_len,
   input  logic              start_dir,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic              req_valid,
   input  logic              req_ready,
   output logic              req_rnw,
   output logic [ADDR_W-1:0] req_addr,
   output logic [CNT_W-1:0]  req_cnt,
   input  logic              rsp_valid,
   input  logic [7:0]        rsp_data,
   output logic              rd_valid,
   output logic [7:0]        rd_data,
   input  logic              wr_in_valid,
   output logic              wr_in_ready,
   input  logic [7:0]        wr_in_data,
   output logic              wr_out_valid,
   input  logic              wr_out_ready,
   output logic [7:0]        wr_out_data
);
   localparam int               STS_W     = STS_BYTES * 8;
   localparam int               ZC_W      = $clog2(ZERO_LIMIT + 1);
   localparam logic [ADDR_W-1:0] STS_ADDR  = ADDR_W'(BASE_ADDR + STS_OFS);
   localparam logic [ADDR_W-1:0] FIFO_ADDR = ADDR_W'(BASE_ADDR + FIFO_OFS);

   generate
      if (MAX_CHUNK < 1) begin : g_bad_chunk
         $error("MAX_CHUNK must be at least 1");
      end
      if (BURST_LSB + BURST_W > STS_W) begin : g_bad_field
         $error("burst field lies outside the status word");
      end
      if (STS_BYTES > MAX_CHUNK) begin : g_bad_sts
         $error("status read does not fit in the count field");
      end
      if (LEN_W < CNT_W) begin : g_bad_len
         $error("LEN_W must cover the chunk count width");
      end
      if (ZERO_LIMIT < 1) begin : g_bad_zl
         $error("ZERO_LIMIT must be at least 1");
      end
   endgenerate

   fbs_state_t          state_q;
   logic                dir_q;
   logic [LEN_W-1:0]    rem_q;
   logic [CNT_W-1:0]    chunk_q;
   logic [ZC_W-1:0]     zcnt_q;
   logic [STS_W-1:0]    sts_word;
   logic                sts_full;
   logic [BURST_W-1:0]  burst;
   logic [CNT_W-1:0]    chunk_w;
   logic                gate_last;
   logic                gate_load;

   fbs_status_capture #(.NBYTES(STS_BYTES), .LITTLE(STS_LE)) u_cap (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (state_q == ST_STS_REQ),
      .byte_valid (rsp_valid && state_q == ST_STS_RX),
      .byte_data  (rsp_data),
      .word       (sts_word),
      .full       (sts_full)
   );

   assign burst = sts_word[BURST_LSB +: BURST_W];

   fbs_chunk_size #(.LEN_W(LEN_W), .BURST_W(BURST_W), .MAX_CHUNK(MAX_CHUNK),
                    .CNT_W(CNT_W)) u_size (
      .remaining (rem_q),
      .burst     (burst),
      .chunk     (chunk_w)
   );

   assign gate_load = (state_q == ST_FIFO_REQ) && req_ready;

   fbs_data_gate #(.CNT_W(CNT_W)) u_gate (
      .clk          (clk),
      .rst_n        (rst_n),
      .load         (gate_load),
      .load_cnt     (chunk_q),
      .is_read      (dir_q),
      .rsp_valid    (rsp_valid),
      .rsp_data     (rsp_data),
      .rd_valid     (rd_valid),
      .rd_data      (rd_data),
      .wr_in_valid  (wr_in_valid),
      .wr_in_ready  (wr_in_ready),
      .wr_in_data   (wr_in_data),
      .wr_out_valid (wr_out_valid),
      .wr_out_ready (wr_out_ready),
      .wr_out_data  (wr_out_data),
      .last         (gate_last)
   );

   always_comb begin
      busy      = (state_q != ST_IDLE);
      req_valid = (state_q == ST_STS_REQ) || (state_q == ST_FIFO_REQ);
      req_rnw   = (state_q == ST_STS_REQ) ? 1'b1 : dir_q;
      req_addr  = (state_q == ST_STS_REQ) ? STS_ADDR : FIFO_ADDR;
      req_cnt   = (state_q == ST_STS_REQ) ? CNT_W'(STS_BYTES) : chunk_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         dir_q   <= 1'b0;
         rem_q   <= '0;
         chunk_q <= '0;
         zcnt_q  <= '0;
         done    <= 1'b0;
         err     <= 1'b0;
      end else begin
         done <= 1'b0;
         err  <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  if (start_len == '0) begin
                     done <= 1'b1;
                  end else begin
                     dir_q   <= start_dir;
                     rem_q   <= start_len;
                     zcnt_q  <= '0;
                     state_q <= ST_STS_REQ;
                  end
               end
            end
            ST_STS_REQ: begin
               if (req_ready) state_q <= ST_STS_RX;
            end
            ST_STS_RX: begin
               if (sts_full) begin
                  if (burst == '0) begin
                     if (zcnt_q == ZC_W'(ZERO_LIMIT - 1)) begin
                        err     <= 1'b1;
                        state_q <= ST_IDLE;
                     end else begin
                        zcnt_q  <= zcnt_q + 1'b1;
                        state_q <= ST_STS_REQ;
                     end
                  end else begin
                     zcnt_q  <= '0;
                     chunk_q <= chunk_w;
                     state_q <= ST_FIFO_REQ;
                  end
               end
            end
            ST_FIFO_REQ: begin
               if (req_ready) state_q <= ST_FIFO_DATA;
            end
            ST_FIFO_DATA: begin
               if (gate_last) begin
                  rem_q <= rem_q - LEN_W'(chunk_q);
                  if (rem_q == LEN_W'(chunk_q)) begin
                     done    <= 1'b1;
                     state_q <= ST_IDLE;
                  end else begin
                     state_q <= ST_STS_REQ;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R1
   chunk_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_addr == FIFO_ADDR) |->
         (req_cnt != '0 && req_cnt <= CNT_W'(MAX_CHUNK) && LEN_W'(req_cnt) <= rem_q));

   // R2
   write_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_rnw) |-> (req_addr == FIFO_ADDR));

   // R6
   rd_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (state_q == ST_FIFO_DATA && dir_q));

   // R7
   wr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_out_valid |-> (state_q == ST_FIFO_DATA && !dir_q));

   // R8
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !err));

   // R5
   err_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!req_valid && !busy));

   // R10
   hold_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (dir_q == $past(dir_q)));

endmodule

// File: tb/sim_fifo_burst_splitter.sv
`timescale 1ns/100ps
module sim_fifo_burst_splitter;
   localparam int          LEN_W = 16;
   localparam int          ZL    = 5;
   localparam int          CNT_W = 7;
   localparam logic [23:0] STS_A  = 24'hD40018;
   localparam logic [23:0] FIFO_A = 24'hD40024;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [LEN_W-1:0] start_len = '0;
   logic start_dir = 1'b0;
   logic busy, done, err;
   logic req_valid, req_rnw;
   logic req_ready = 1'b1;
   logic [23:0] req_addr;
   logic [CNT_W-1:0] req_cnt;
   logic rsp_valid = 1'b0;
   logic [7:0] rsp_data = '0;
   logic rd_valid;
   logic [7:0] rd_data;
   logic wr_in_valid = 1'b1;
   logic wr_in_ready;
   logic [7:0] wr_in_data = '0;
   logic wr_out_valid;
   logic wr_out_ready = 1'b0;
   logic [7:0] wr_out_data;

   always #2 clk = ~clk;

   fifo_burst_splitter #(.LEN_W(LEN_W), .ZERO_LIMIT(ZL)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .start_len(start_len),
      .start_dir(start_dir), .busy(busy), .done(done), .err(err),
      .req_valid(req_valid), .req_ready(req_ready), .req_rnw(req_rnw),
      .req_addr(req_addr), .req_cnt(req_cnt), .rsp_valid(rsp_valid),
      .rsp_data(rsp_data), .rd_valid(rd_valid), .rd_data(rd_data),
      .wr_in_valid(wr_in_valid), .wr_in_ready(wr_in_ready),
      .wr_in_data(wr_in_data), .wr_out_valid(wr_out_valid),
      .wr_out_ready(wr_out_ready), .wr_out_data(wr_out_data));

   int n_chk = 0;
   int n_bad = 0;

   // framer model state
   int ph = 0;
   int k = 0;
   int chunk_left = 0;
   int rem_b = 0;
   int exp_dir = 0;
   int zero_run = 0;
   int zeros_given = 0;
   int bmode = 0;
   int bmax = 8;
   int last_burst = 0;
   int saw_sts = 0;
   int n_req = 0, n_sts = 0, n_fifo = 0;
   int rd_idx = 0, wr_idx = 0;
   logic [7:0] sts_b [4];

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] rd_pat(input int i);
      return 8'(i * 37 + 11);
   endfunction

   function automatic logic [7:0] wr_pat(input int i);
      return 8'(i * 53 + 29);
   endfunction

   function automatic int exp_chunk(input int rem, input int bur);
      int m;
      m = (rem < bur) ? rem : bur;
      return (m < 64) ? m : 64;
   endfunction

   function automatic int pick_burst();
      if (bmode == 2) return $urandom_range(65, 1000);
      if (bmode == 1 && $urandom_range(0, 3) == 0) return $urandom_range(65, 1000);
      return $urandom_range(1, bmax);
   endfunction

   task automatic handle_req();
      int b, e;
      n_req++;
      if (req_addr == STS_A) begin
         chk(req_rnw == 1'b1, "R2", req_rnw, 1);
         chk(req_cnt == 7'd4, "R2", req_cnt, 4);
         n_sts++;
         saw_sts = 1;
         if (zeros_given < zero_run) begin
            b = 0;
            zeros_given++;
         end else begin
            b = pick_burst();
            zeros_given = 0;
         end
         last_burst = b;
         sts_b[0] = 8'($urandom);
         sts_b[1] = 8'(b);
         sts_b[2] = 8'(b >> 8);
         sts_b[3] = 8'($urandom);
         k = 0;
         ph = 1;
      end else begin
         chk(req_addr == FIFO_A, "R2", req_addr, FIFO_A);
         chk(req_rnw == 1'(exp_dir), "R2", req_rnw, exp_dir);
         chk(saw_sts == 1 && last_burst != 0, "R3", saw_sts, 1);
         e = exp_chunk(rem_b, last_burst);
         chk(int'(req_cnt) == e, "R1", req_cnt, e);
         saw_sts = 0;
         n_fifo++;
         chunk_left = int'(req_cnt);
         rem_b -= int'(req_cnt);
         if (chunk_left == 0) ph = 0;
         else ph = (exp_dir != 0) ? 2 : 3;
      end
   endtask

   // framer / slave model: drive after negedge, observe 1 ns later
   initial begin
      forever begin
         @(negedge clk);
         wr_in_data = wr_pat(wr_idx);
         case (ph)
            1: begin rsp_valid = 1'b1; rsp_data = sts_b[k]; wr_out_ready = 1'b0; end
            2: begin rsp_valid = 1'b1; rsp_data = rd_pat(rd_idx); wr_out_ready = 1'b0; end
            3: begin rsp_valid = 1'b0; wr_out_ready = ($urandom_range(0, 3) != 0); end
            default: begin rsp_valid = 1'b0; wr_out_ready = 1'b0; end
         endcase
         #1;
         if (rst_n) begin
            if (ph != 2) chk(rd_valid == 1'b0, "R6", rd_valid, 0);
            if (ph != 3) chk(wr_out_valid == 1'b0 && wr_in_ready == 1'b0, "R7", wr_out_valid, 0);
            case (ph)
               1: begin
                  k++;
                  if (k == 4) ph = 0;
               end
               2: begin
                  chk(rd_valid == 1'b1 && rd_data == rd_pat(rd_idx), "R6", rd_data, rd_pat(rd_idx));
                  rd_idx++;
                  chunk_left--;
                  if (chunk_left == 0) ph = 0;
               end
               3: begin
                  chk(wr_out_valid == 1'b1, "R7", wr_out_valid, 1);
                  if (wr_out_valid && wr_out_ready) begin
                     chk(wr_out_data == wr_pat(wr_idx) && wr_in_ready, "R7", wr_out_data, wr_pat(wr_idx));
                     wr_idx++;
                     chunk_left--;
                     if (chunk_left == 0) ph = 0;
                  end
               end
               default: if (req_valid) handle_req();
            endcase
         end
      end
   end

   task automatic run_xfer(input int len, input int dir, input int zrun,
                           input int bm, input int bx, input bit exp_err, input bit mid);
      bit got_done, got_err;
      int done_c;
      rem_b = len; exp_dir = dir; zero_run = zrun; zeros_given = 0;
      bmode = bm; bmax = bx; last_burst = 0; saw_sts = 0;
      n_req = 0; n_sts = 0; n_fifo = 0; rd_idx = 0; wr_idx = 0;
      got_done = 0; got_err = 0; done_c = -1;
      @(negedge clk);
      start = 1'b1; start_len = LEN_W'(len); start_dir = 1'(dir);
      @(negedge clk);
      start = 1'b0;
      for (int c = 0; c < 60000; c++) begin
         if (mid && c == 2) begin start = 1'b1; start_len = 16'd7; start_dir = ~1'(dir); end
         if (mid && c == 3) start = 1'b0;
         #1.5;
         if (done) got_done = 1;
         if (err) got_err = 1;
         if (got_done || got_err) begin done_c = c; break; end
         @(negedge clk);
      end
      if (exp_err) begin
         chk(got_err && !got_done, "R5", got_err, 1);
         chk(n_fifo == 0, "R5", n_fifo, 0);
         chk(n_sts == ZL, "R5", n_sts, ZL);
         chk(busy == 1'b0, "R5", busy, 0);
      end else begin
         chk(got_done && !got_err, "R8", got_done, 1);
         chk(busy == 1'b0, "R8", busy, 0);
         chk(rem_b == 0, "R8", rem_b, 0);
         if (len == 0) begin
            chk(done_c == 0, "R9", done_c, 0);
            chk(n_req == 0, "R9", n_req, 0);
         end
         if (mid) chk(((dir != 0) ? rd_idx : wr_idx) == len, "R10", (dir != 0) ? rd_idx : wr_idx, len);
         else     chk(((dir != 0) ? rd_idx : wr_idx) == len, "R8", (dir != 0) ? rd_idx : wr_idx, len);
      end
      @(negedge clk);
      #1.5;
      chk(done == 1'b0 && err == 1'b0, "R8", done, 0);
   endtask

   initial begin
      void'($urandom(32'h1bad5eed));
      repeat (3) @(negedge clk);
      #1.5;
      // R11 reset state
      chk(busy == 1'b0 && done == 1'b0 && err == 1'b0 && req_valid == 1'b0, "R11", busy, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1.5;
      chk(busy == 1'b0 && req_valid == 1'b0, "R11", req_valid, 0);

      run_xfer(10, 1, 0, 0, 8, 0, 0);      // read, small bursts (R1, R3, R6)
      run_xfer(100, 0, 0, 1, 30, 0, 0);    // write, mixed bursts (R7)
      run_xfer(200, 1, 0, 2, 8, 0, 0);     // read, cap at 64 (R1)
      run_xfer(130, 0, 0, 2, 8, 0, 0);     // write, cap at 64 (R1)
      run_xfer(1, 0, 0, 0, 1, 0, 0);       // single byte
      run_xfer(5, 1, ZL - 1, 0, 8, 0, 0);  // R4 recovers after zeros
      chk(n_sts >= ZL, "R4", n_sts, ZL);
      run_xfer(9, 1, ZL, 0, 8, 1, 0);      // R5 retry limit
      run_xfer(0, 1, 0, 0, 8, 0, 0);       // R9 zero length
      run_xfer(40, 1, 0, 0, 6, 0, 1);      // R10 start while busy
      run_xfer(40, 0, 0, 0, 6, 0, 1);      // R10 start while busy
      for (int t = 0; t < 10; t++)
         run_xfer($urandom_range(1, 150), $urandom_range(0, 1), $urandom_range(0, 2),
                  $urandom_range(0, 2), $urandom_range(1, 70), 0, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule